// File: doc/BRIEF.md
# Serial Engine Command Decoder

This block sits between a host-side byte FIFO and a serial shift engine. It reads a stream of opcode bytes and their arguments over a valid/ready handshake and turns each command into an action. Some commands write an 8-bit low GPIO bank, which has separate level and output-enable registers. Some sample pin levels and return one byte. Some load the clock divisor or switch the divide-by-5 prescaler. The rest start a job on the shift engine.

An opcode with bit 7 set is a special command. An opcode with bit 7 clear is a shift transfer. Its low bits select the options, and bit 1 chooses whether the length counts bits or bytes. For a transfer with data out, the decoder passes the payload bytes that follow the length to the engine, one at a time. Read results and error codes go back to the host through a small response FIFO inside the block.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After a synchronous active-high reset, `gpio_out`, `gpio_oe` and `clk_div` are 0, `presc_en` is 0, and `resp_valid`, `job_valid` and `pay_valid` are low.
- R2: Opcode 0x80 takes two argument bytes: first the pin levels, then the output-enable mask, where a 1 makes the pin an output. `gpio_out` and `gpio_oe` both change together, one cycle after the second argument is accepted, and not before.
- R3: Opcode 0x81 queues one response byte equal to `pins_lo`, and opcode 0x83 queues one equal to `pins_hi`. Each value is sampled in the cycle the opcode is accepted.
- R4: Opcode 0x86 takes a 16-bit divisor, low byte first. `clk_div` takes the whole value one cycle after the high byte is accepted.
- R5: Opcode 0x8B sets `presc_en` to 1 and opcode 0x8A clears it. Either change appears one cycle after the opcode is accepted.
- R6: An opcode with bit 7 = 0 and bit 1 = 0 is a byte-count transfer. It takes two length bytes, low byte first, holding the byte count minus one. The job it issues has `job_kind` = 0, `job_flags` = opcode[6:0] and `job_len` = that 16-bit value. If bit 4 (data out) is set, exactly `job_len`+1 payload bytes follow. Each one is presented on `pay_data` with `pay_valid` high, one cycle after it is accepted.
- R7: An opcode with bit 7 = 0 and bit 1 = 1 is a bit-count transfer. It takes one length byte holding the bit count minus one, and the job it issues has `job_kind` = 0 and `job_len` equal to that byte zero-extended. If bit 4 is set, one payload byte follows and is forwarded as in R6.
- R8: Opcode 0x8E takes one count byte and issues a job with `job_kind` = 1. Opcode 0x8F takes two count bytes, low byte first, and issues a job with `job_kind` = 2. Both jobs have `job_flags` = 0 and no payload.
- R9: Any other opcode with bit 7 set queues the response 0xFA followed by the opcode itself. Parsing then resumes with the next byte, which is read as an opcode.
- R10: While waiting for an opcode, `in_ready` is low when `eng_busy` is high or when the response FIFO has fewer than two free entries. `in_ready` is also low in the single cycle after an unknown opcode. While the decoder is collecting arguments or payload, `in_ready` is high.
- R11: Responses leave in the order they were queued. `resp_data` holds steady while `resp_valid` is high and `resp_ready` is low.
- R12: `job_valid` is a single-cycle pulse, one cycle after the last length byte is accepted. It never coincides with `pay_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Command stream byte |
| in_valid | input | 1 | Command byte present |
| in_ready | output | 1 | Decoder accepts the byte this cycle |
| resp_data | output | 8 | Head of the response FIFO |
| resp_valid | output | 1 | Response FIFO not empty |
| resp_ready | input | 1 | Host takes the response byte |
| eng_busy | input | 1 | Shift engine still working on a job |
| job_valid | output | 1 | One-cycle job start pulse |
| job_kind | output | 2 | 0 shift, 1 clock bits, 2 clock bytes |
| job_flags | output | 7 | Transfer option bits (opcode[6:0]) |
| job_len | output | 16 | Count minus one |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte for the engine |
| pins_lo | input | 8 | Pin levels of the low bank |
| pins_hi | input | 8 | Pin levels of the high bank |
| gpio_out | output | 8 | Low bank output levels |
| gpio_oe | output | 8 | Low bank output enables, 1 = drive |
| clk_div | output | 16 | Clock divisor |
| presc_en | output | 1 | Divide-by-5 prescaler on |

## Verification
The assertions assume that reset is held over at least one rising edge before traffic starts. They also assume that every input is stable across each rising edge, so that an accepted byte is the one seen in the cycle before a strobe. The bench changes every input one nanosecond after a rising edge and samples at the falling edge. It holds `eng_busy` high and `resp_ready` low for long stretches, so that both stall conditions and full-FIFO back-pressure occur. It also sends opcodes while the decoder is waiting for an argument, so that those bytes must be treated as data.

// File: rtl/sed_pkg.sv
package sed_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_GPIO_SET  = 8'h80;
    localparam logic [BYTE_W-1:0] OP_RD_LO     = 8'h81;
    localparam logic [BYTE_W-1:0] OP_RD_HI     = 8'h83;
    localparam logic [BYTE_W-1:0] OP_DIV_SET   = 8'h86;
    localparam logic [BYTE_W-1:0] OP_PRE_OFF   = 8'h8A;
    localparam logic [BYTE_W-1:0] OP_PRE_ON    = 8'h8B;
    localparam logic [BYTE_W-1:0] OP_CLK_BITS  = 8'h8E;
    localparam logic [BYTE_W-1:0] OP_CLK_BYTES = 8'h8F;
    localparam logic [BYTE_W-1:0] RSP_BAD_OP   = 8'hFA;

    localparam int FLAG_BITS = 1;   // count bits instead of bytes
    localparam int FLAG_DOUT = 4;   // payload follows the length

    typedef enum logic [2:0] {
        ST_OP,
        ST_ARG0,
        ST_ARG1,
        ST_PAY,
        ST_ERR
    } pstate_e;

    typedef enum logic [1:0] {
        JOB_SHIFT     = 2'd0,
        JOB_CLK_BITS  = 2'd1,
        JOB_CLK_BYTES = 2'd2
    } job_kind_e;

    typedef struct packed {
        job_kind_e         kind;
        logic [6:0]        flags;
        logic [LEN_W-1:0]  len_m1;
    } job_t;

    typedef struct packed {
        logic              gpio_we;
        logic [BYTE_W-1:0] gpio_val;
        logic [BYTE_W-1:0] gpio_dir;
        logic              div_we;
        logic [LEN_W-1:0]  div_val;
        logic              pre_we;
        logic              pre_val;
    } cfg_upd_t;

    function automatic logic is_xfer(input logic [BYTE_W-1:0] op);
        return !op[BYTE_W-1];
    endfunction

    function automatic logic needs_arg(input logic [BYTE_W-1:0] op);
        return (op == OP_GPIO_SET) || (op == OP_DIV_SET) ||
               (op == OP_CLK_BITS) || (op == OP_CLK_BYTES);
    endfunction

endpackage

// File: rtl/sed_resp_fifo.sv
module sed_resp_fifo
    import sed_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic              not_empty,
    output logic              room2
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wr_q, rd_q;
    logic [CW-1:0]     cnt_q;
    logic              do_pop;

    assign do_pop    = pop && (cnt_q != '0);
    assign not_empty = (cnt_q != '0);
    assign head      = mem_q[rd_q];
    assign room2     = (int'(cnt_q) + 2 <= DEPTH);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_data;
                wr_q        <= bump(wr_q);
            end
            if (do_pop) rd_q <= bump(rd_q);
            if (push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (!push && do_pop) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sed_parser.sv
module sed_parser
    import sed_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              eng_busy,
    input  logic              room2,
    input  logic [BYTE_W-1:0] pins_lo,
    input  logic [BYTE_W-1:0] pins_hi,
    output logic              push,
    output logic [BYTE_W-1:0] push_data,
    output cfg_upd_t          cfg,
    output logic              job_valid,
    output job_t              job,
    output logic              pay_valid,
    output logic [BYTE_W-1:0] pay_data
);
    pstate_e            st_q, st_d;
    logic [BYTE_W-1:0]  op_q, op_d;
    logic [BYTE_W-1:0]  a0_q, a0_d;
    logic [LEN_W:0]     rem_q, rem_d;
    logic               acc;
    logic               job_v_d, pay_v_d;
    job_t               job_d;
    logic [LEN_W-1:0]   len_w;

    assign len_w = {in_data, a0_q};

    always_comb begin
        in_ready  = (st_q == ST_OP) ? (!eng_busy && room2) : (st_q != ST_ERR);
        acc       = in_valid && in_ready;
        st_d      = st_q;
        op_d      = op_q;
        a0_d      = a0_q;
        rem_d     = rem_q;
        push      = 1'b0;
        push_data = '0;
        cfg       = '0;
        job_v_d   = 1'b0;
        job_d     = '0;
        pay_v_d   = 1'b0;
        unique case (st_q)
            ST_OP: if (acc) begin
                op_d = in_data;
                if (is_xfer(in_data) || needs_arg(in_data)) begin
                    st_d = ST_ARG0;
                end else if (in_data == OP_RD_LO) begin
                    push      = 1'b1;
                    push_data = pins_lo;
                end else if (in_data == OP_RD_HI) begin
                    push      = 1'b1;
                    push_data = pins_hi;
                end else if (in_data == OP_PRE_OFF || in_data == OP_PRE_ON) begin
                    cfg.pre_we  = 1'b1;
                    cfg.pre_val = in_data[0];
                end else begin
                    push      = 1'b1;
                    push_data = RSP_BAD_OP;
                    st_d      = ST_ERR;
                end
            end
            ST_ARG0: if (acc) begin
                a0_d = in_data;
                if (is_xfer(op_q) && op_q[FLAG_BITS]) begin
                    job_v_d      = 1'b1;
                    job_d.kind   = JOB_SHIFT;
                    job_d.flags  = op_q[6:0];
                    job_d.len_m1 = LEN_W'(in_data);
                    if (op_q[FLAG_DOUT]) begin
                        rem_d = (LEN_W+1)'(1);
                        st_d  = ST_PAY;
                    end else begin
                        st_d = ST_OP;
                    end
                end else if (op_q == OP_CLK_BITS) begin
                    job_v_d      = 1'b1;
                    job_d.kind   = JOB_CLK_BITS;
                    job_d.len_m1 = LEN_W'(in_data);
                    st_d         = ST_OP;
                end else begin
                    st_d = ST_ARG1;
                end
            end
            ST_ARG1: if (acc) begin
                st_d = ST_OP;
                if (is_xfer(op_q)) begin
                    job_v_d      = 1'b1;
                    job_d.kind   = JOB_SHIFT;
                    job_d.flags  = op_q[6:0];
                    job_d.len_m1 = len_w;
                    if (op_q[FLAG_DOUT]) begin
                        rem_d = {1'b0, len_w} + (LEN_W+1)'(1);
                        st_d  = ST_PAY;
                    end
                end else if (op_q == OP_GPIO_SET) begin
                    cfg.gpio_we  = 1'b1;
                    cfg.gpio_val = a0_q;
                    cfg.gpio_dir = in_data;
                end else if (op_q == OP_DIV_SET) begin
                    cfg.div_we  = 1'b1;
                    cfg.div_val = len_w;
                end else begin
                    job_v_d      = 1'b1;
                    job_d.kind   = JOB_CLK_BYTES;
                    job_d.len_m1 = len_w;
                end
            end
            ST_PAY: if (acc) begin
                pay_v_d = 1'b1;
                rem_d   = rem_q - 1'b1;
                if (rem_q == (LEN_W+1)'(1)) st_d = ST_OP;
            end
            ST_ERR: begin
                push      = 1'b1;
                push_data = op_q;
                st_d      = ST_OP;
            end
            default: st_d = ST_OP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_OP;
            op_q      <= '0;
            a0_q      <= '0;
            rem_q     <= '0;
            job_valid <= 1'b0;
            job       <= '0;
            pay_valid <= 1'b0;
            pay_data  <= '0;
        end else begin
            st_q      <= st_d;
            op_q      <= op_d;
            a0_q      <= a0_d;
            rem_q     <= rem_d;
            job_valid <= job_v_d;
            pay_valid <= pay_v_d;
            if (job_v_d) job <= job_d;
            if (pay_v_d) pay_data <= in_data;
        end
    end
endmodule

// File: rtl/sed_cfg_regs.sv
module sed_cfg_regs
    import sed_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_upd_t          upd,
    output logic [BYTE_W-1:0] gpio_out,
    output logic [BYTE_W-1:0] gpio_oe,
    output logic [LEN_W-1:0]  clk_div,
    output logic              presc_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gpio_out <= '0;
            gpio_oe  <= '0;
            clk_div  <= '0;
            presc_en <= 1'b0;
        end else begin
            if (upd.gpio_we) begin
                gpio_out <= upd.gpio_val;
                gpio_oe  <= upd.gpio_dir;
            end
            if (upd.div_we) clk_div  <= upd.div_val;
            if (upd.pre_we) presc_en <= upd.pre_val;
        end
    end
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
    import sed_pkg::*;
#(
    parameter int RESP_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [7:0]  resp_data,
    output logic        resp_valid,
    input  logic        resp_ready,
    input  logic        eng_busy,
    output logic        job_valid,
    output logic [1:0]  job_kind,
    output logic [6:0]  job_flags,
    output logic [15:0] job_len,
    output logic        pay_valid,
    output logic [7:0]  pay_data,
    input  logic [7:0]  pins_lo,
    input  logic [7:0]  pins_hi,
    output logic [7:0]  gpio_out,
    output logic [7:0]  gpio_oe,
    output logic [15:0] clk_div,
    output logic        presc_en
);
    logic              push, room2;
    logic [BYTE_W-1:0] push_data;
    cfg_upd_t          upd;
    job_t              job;

    sed_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .eng_busy  (eng_busy),
        .room2     (room2),
        .pins_lo   (pins_lo),
        .pins_hi   (pins_hi),
        .push      (push),
        .push_data (push_data),
        .cfg       (upd),
        .job_valid (job_valid),
        .job       (job),
        .pay_valid (pay_valid),
        .pay_data  (pay_data)
    );

    sed_resp_fifo #(.DEPTH(RESP_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (resp_ready),
        .head      (resp_data),
        .not_empty (resp_valid),
        .room2     (room2)
    );

    sed_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe),
        .clk_div  (clk_div),
        .presc_en (presc_en)
    );

    assign job_kind  = job.kind;
    assign job_flags = job.flags;
    assign job_len   = job.len_m1;
endmodule

// File: rtl/sed_checker.sv
module sed_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [7:0]  resp_data,
    input logic        resp_valid,
    input logic        resp_ready,
    input logic        job_valid,
    input logic        pay_valid,
    input logic [7:0]  gpio_out,
    input logic [7:0]  gpio_oe,
    input logic [15:0] clk_div,
    input logic        presc_en
);
    // R2
    gpio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid && in_ready) |-> ($stable(gpio_out) && $stable(gpio_oe)));

    // R4
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid && in_ready) |-> $stable(clk_div));

    // R5
    presc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid && in_ready) |-> $stable(presc_en));

    // R6
    pay_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        pay_valid |-> $past(in_valid && in_ready));

    // R11
    resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

    // R12
    job_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        job_valid |-> $past(in_valid && in_ready));

    // R12
    job_pay_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(job_valid && pay_valid));
endmodule

bind serial_cmd_decoder sed_checker u_sed_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .resp_data  (resp_data),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .job_valid  (job_valid),
    .pay_valid  (pay_valid),
    .gpio_out   (gpio_out),
    .gpio_oe    (gpio_oe),
    .clk_div    (clk_div),
    .presc_en   (presc_en)
);

// File: tb/tb_serial_cmd_decoder.sv
module tb_serial_cmd_decoder;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  resp_data;
    logic        resp_valid;
    logic        resp_ready = 1'b1;
    logic        eng_busy = 1'b0;
    logic        job_valid;
    logic [1:0]  job_kind;
    logic [6:0]  job_flags;
    logic [15:0] job_len;
    logic        pay_valid;
    logic [7:0]  pay_data;
    logic [7:0]  pins_lo = 8'h00;
    logic [7:0]  pins_hi = 8'h00;
    logic [7:0]  gpio_out, gpio_oe;
    logic [15:0] clk_div;
    logic        presc_en;

    serial_cmd_decoder #(.RESP_DEPTH(DEPTH)) dut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int          mst = 0;       // 0 opcode, 1 first arg, 2 second arg, 3 payload, 4 error cycle
    logic [7:0]  mop, ma0;
    int          mrem;
    logic [7:0]  rq[$];
    logic [7:0]  m_gpio = 0, m_oe = 0;
    logic [15:0] m_div = 0;
    logic        m_pre = 0;
    logic        e_jv = 0, e_pv = 0;
    logic [1:0]  e_kind;
    logic [6:0]  e_flags;
    logic [15:0] e_len;
    logic [7:0]  e_pd;
    string       e_tag;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic exp_job(input logic [1:0] k, input logic [6:0] f, input logic [15:0] l, input string tag);
        e_jv = 1; e_kind = k; e_flags = f; e_len = l; e_tag = tag;
    endtask

    task automatic model_byte(input logic [7:0] b);
        case (mst)
            0: begin
                mop = b;
                if (!b[7]) mst = 1;
                else case (b)
                    8'h80, 8'h86, 8'h8E, 8'h8F: mst = 1;
                    8'h81: rq.push_back(pins_lo);
                    8'h83: rq.push_back(pins_hi);
                    8'h8A: m_pre = 0;
                    8'h8B: m_pre = 1;
                    default: begin rq.push_back(8'hFA); rq.push_back(b); mst = 4; end
                endcase
            end
            1: begin
                ma0 = b;
                if (!mop[7] && mop[1]) begin
                    exp_job(2'd0, mop[6:0], {8'h00, b}, "R7");
                    if (mop[4]) begin mrem = 1; mst = 3; end else mst = 0;
                end else if (mop == 8'h8E) begin
                    exp_job(2'd1, 7'h0, {8'h00, b}, "R8");
                    mst = 0;
                end else mst = 2;
            end
            2: begin
                mst = 0;
                if (!mop[7]) begin
                    exp_job(2'd0, mop[6:0], {b, ma0}, "R6");
                    if (mop[4]) begin mrem = int'({b, ma0}) + 1; mst = 3; end
                end else if (mop == 8'h80) begin m_gpio = ma0; m_oe = b; end
                else if (mop == 8'h86) m_div = {b, ma0};
                else exp_job(2'd2, 7'h0, {b, ma0}, "R8");
            end
            3: begin
                e_pv = 1; e_pd = b;
                mrem--;
                if (mrem == 0) mst = 0;
            end
            default: ;
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            // R10 ready
            if (mst == 4) begin
                chk("R10 err-cycle ready", in_ready, 0);
                mst = 0;
            end else if (mst == 0)
                chk("R10 opcode ready", in_ready, !eng_busy && (DEPTH - rq.size() >= 2));
            else
                chk("R10 arg ready", in_ready, 1);
            chk("R2 gpio_out", gpio_out, m_gpio);
            chk("R2 gpio_oe", gpio_oe, m_oe);
            chk("R4 clk_div", clk_div, m_div);
            chk("R5 presc_en", presc_en, m_pre);
            chk("R12 job_valid", job_valid, e_jv);
            if (e_jv && job_valid) begin
                chk({e_tag, " job_kind"}, job_kind, e_kind);
                chk({e_tag, " job_flags"}, job_flags, e_flags);
                chk({e_tag, " job_len"}, job_len, e_len);
            end
            chk("R6 pay_valid", pay_valid, e_pv);
            if (e_pv && pay_valid) chk("R6 pay_data", pay_data, e_pd);
            e_jv = 0; e_pv = 0;
            chk("R11 resp_valid", resp_valid, rq.size() != 0);
            if (resp_valid && rq.size() != 0) begin
                chk("R3/R9 resp_data (R11 order)", resp_data, rq[0]);
                if (resp_ready) void'(rq.pop_front());
            end
            if (in_valid && in_ready) model_byte(in_data);
        end
    end

    task automatic send(input logic [7:0] b);
        in_data = b; in_valid = 1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 gpio_out", gpio_out, 0);
        chk("R1 gpio_oe", gpio_oe, 0);
        chk("R1 clk_div", clk_div, 0);
        chk("R1 presc_en", presc_en, 0);
        chk("R1 resp_valid", resp_valid, 0);
        chk("R1 job/pay", {job_valid, pay_valid}, 0);
        @(posedge clk); #1;

        // R2 pin levels then enables
        send(8'h80); send(8'hA5); send(8'h3C); idle(2);
        // R2 argument bytes that look like opcodes are data
        send(8'h80); send(8'h81); send(8'hFA); idle(2);
        // R4 divisor
        send(8'h86); send(8'h34); send(8'h12); idle(2);
        // R5 prescaler
        send(8'h8B); idle(2); send(8'h8A); idle(1); send(8'h8B); idle(2);
        // R3 pin reads
        pins_lo = 8'h5A; pins_hi = 8'hC3;
        send(8'h81); send(8'h83); idle(3);
        // R6 byte transfer with payload of three bytes
        send(8'h11); send(8'h02); send(8'h00);
        send(8'hDE); send(8'h86); send(8'hAD); idle(2);
        // R6 read-only byte transfer, large length, no payload
        send(8'h20); send(8'hFF); send(8'h01); idle(2);
        // R7 bit transfer with one data byte
        send(8'h33); send(8'h05); send(8'hAB); idle(2);
        // R7 read-only bit transfer
        send(8'h22); send(8'h07); idle(2);
        // R8 clock-only jobs
        send(8'h8E); send(8'h06); idle(1);
        send(8'h8F); send(8'h03); send(8'h01); idle(2);
        // R9 unknown special opcode, then recovery
        send(8'h84); send(8'h80); send(8'h01); send(8'hFF); idle(3);
        send(8'h9E); send(8'h81); idle(4);
        // R10 engine busy stall
        eng_busy = 1;
        fork
            send(8'h83);
            begin idle(6); eng_busy = 0; end
        join
        idle(2);
        // R10 busy does not stall argument collection
        send(8'h86);
        eng_busy = 1;
        send(8'h01); send(8'h00);
        idle(3); eng_busy = 0; idle(1);
        // R10/R11 full response FIFO back-pressure
        resp_ready = 0;
        pins_lo = 8'h11;
        fork
            begin send(8'h81); pins_lo = 8'h22; send(8'h81); pins_lo = 8'h33; send(8'h81); send(8'h81); end
            begin idle(12); resp_ready = 1; end
        join
        idle(4);
        resp_ready = 0;
        send(8'h99);
        idle(4); resp_ready = 1; idle(6);
        finish_run();
    end
endmodule